// File: doc/BRIEF.md
# 100BASE-X Receive Code-Group Decoder

This block sits after symbol alignment and descrambling in a 100 Mb/s receive path. It takes one aligned 5-bit code-group per clock and rebuilds the receive side of a Media Independent Interface (MII): the data-valid flag, the error flag and the 4-bit nibble. A stream opens on the J then K delimiter pair and closes on the T then R pair. Data code-groups turn into nibbles. Illegal code-groups inside a stream raise the error flag. Any carrier that does not begin with a proper J/K pair is reported as a false carrier.

Two statistics counters are kept. The false-carrier counter counts events and holds at its top value. The receive-error counter counts bad packets and rolls over. A single read strobe clears both. A warning pulse fires when either counter's top bit first becomes set. Two false carriers in a row, with no good start-of-stream between them, drop the link-good output and pulse a link-change flag. A raw mode skips the 4B5B mapping and passes 5-bit code-groups straight through.

Top module: `fx_rx_decoder`

## Requirements
- R1: Inside a stream, each of the 16 data code-groups (0:11110 1:01001 2:10100 3:10101 4:01010 5:01011 6:01110 7:01111 8:10010 9:10011 A:10110 B:10111 C:11010 D:11011 E:11100 F:11101) appears on `rxd` with `rx_dv`=1 and `rx_er`=0. The output comes one clock after the code-group is sampled.
- R2: J (11000) followed by K (10001) starts a stream. The J slot shows `rx_dv`=0. The K slot shows `rx_dv`=1 with `rxd`=0101. `rx_dv` rises only in a K slot.
- R3: Idle (11111) between streams gives `rx_dv`=0, `rx_er`=0 and `rxd`=0000. The T (01101) slot and the R (00111) slot both show `rx_dv`=0.
- R4: Inside a stream, any code-group other than a data code, T or I (for example 00000..00011, 00100, J, K, R) is a code violation. It is shown as `rx_dv`=1 with `rx_er`=1.
- R5: A non-idle code-group other than J while idle starts a false carrier. So does a code-group after J that is not K. Each slot of the event shows `rx_dv`=0, `rx_er`=1 and `rxd`=1110. The event ends on the next idle.
- R6: `fc_count` (CNT_W bits, 16 by default) rises by one as the ending idle slot is output. It holds at its all-ones value.
- R7: `err_count` (CNT_W bits) rises by exactly one when a packet with one or more errors ends, however many errors the packet holds. It rolls over from all-ones to zero.
- R8: When `cnt_rd` is high at a clock edge, both counters clear. An increment that falls at that same edge is kept, so the counter then reads 1.
- R9: `link_ok` is 1 after reset. A second false carrier with no valid J/K between it and the previous one clears `link_ok`. The next valid J/K sets it again. Each change of `link_ok` comes with a one-clock `link_chg` pulse at the same edge.
- R10: `cnt_warn` pulses for one clock when the top bit of either counter goes from 0 to 1.
- R11: With `bypass`=1, stream slots carry the raw code-group on {`rxd4`,`rxd`}. False-carrier slots carry 11110 with `rx_dv`=0, and `rx_er` stays 0.
- R12: A stream that ends early counts as a bad packet. This covers an idle inside the stream, whose slot shows `rx_dv`=1 and `rx_er`=1. It also covers a T not followed by R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Code-group clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cg | input | 5 | Aligned, descrambled code-group |
| bypass | input | 1 | Raw 5-bit output mode |
| cnt_rd | input | 1 | Clear-on-read strobe for both counters |
| rx_dv | output | 1 | Receive data valid |
| rx_er | output | 1 | Receive error / false-carrier flag |
| rxd | output | 4 | Receive nibble (low bits of raw code in bypass) |
| rxd4 | output | 1 | Top bit of raw code in bypass, else 0 |
| fc_count | output | CNT_W | Saturating false-carrier count |
| err_count | output | CNT_W | Wrapping bad-packet count |
| cnt_warn | output | 1 | Counter top-bit early-warning pulse |
| link_ok | output | 1 | Link-good status |
| link_chg | output | 1 | Link-status-change pulse |

## Verification
The clear-on-read strobe and a counter increment can meet on one clock edge. The bench provokes this by raising `cnt_rd` in the idle slot that ends a false carrier. It does the same in the R slot that closes a corrupted packet. It judges the result by requiring the counter to read 1 rather than 0, while the other counter reads 0. The link drop also falls on the same edge as a false-carrier count. The bench checks `link_ok`, `link_chg` and `fc_count` together in that slot.

// File: rtl/fxd_pkg.sv
package fxd_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_GOT_J, S_DATA, S_GOT_T, S_FALSE
  } fr_state_t;

  localparam logic [4:0] CG_I = 5'b11111;
  localparam logic [4:0] CG_J = 5'b11000;
  localparam logic [4:0] CG_K = 5'b10001;
  localparam logic [4:0] CG_T = 5'b01101;
  localparam logic [4:0] CG_R = 5'b00111;
  localparam logic [3:0] NIB_PRE = 4'b0101;
  localparam logic [3:0] NIB_FC  = 4'b1110;
  localparam logic [4:0] RAW_FC  = 5'b11110;

  // returns {valid, nibble}
  function automatic logic [4:0] dec_cg(input logic [4:0] c);
    case (c)
      5'b11110: return 5'h10;
      5'b01001: return 5'h11;
      5'b10100: return 5'h12;
      5'b10101: return 5'h13;
      5'b01010: return 5'h14;
      5'b01011: return 5'h15;
      5'b01110: return 5'h16;
      5'b01111: return 5'h17;
      5'b10010: return 5'h18;
      5'b10011: return 5'h19;
      5'b10110: return 5'h1A;
      5'b10111: return 5'h1B;
      5'b11010: return 5'h1C;
      5'b11011: return 5'h1D;
      5'b11100: return 5'h1E;
      5'b11101: return 5'h1F;
      default:  return 5'h00;
    endcase
  endfunction

  // next value of a statistics counter
  function automatic logic [31:0] cnt_step(input logic [31:0] cur, input logic [31:0] top,
                                           input logic inc, input logic clr, input logic sat);
    logic [31:0] base;
    base = clr ? 32'd0 : cur;
    if (!inc) return base;
    if (sat && base == top) return base;
    return (base == top) ? 32'd0 : base + 32'd1;
  endfunction
endpackage

// File: rtl/fxd_sym_map.sv
module fxd_sym_map
  import fxd_pkg::*;
(
  input  logic [4:0] cg,
  output logic       data_ok,
  output logic [3:0] nib,
  output logic       is_i,
  output logic       is_j,
  output logic       is_k,
  output logic       is_t,
  output logic       is_r
);
  logic [4:0] dec;
  assign dec     = dec_cg(cg);
  assign data_ok = dec[4];
  assign nib     = dec[3:0];
  assign is_i    = (cg == CG_I);
  assign is_j    = (cg == CG_J);
  assign is_k    = (cg == CG_K);
  assign is_t    = (cg == CG_T);
  assign is_r    = (cg == CG_R);
endmodule

// File: rtl/fxd_frame_fsm.sv
module fxd_frame_fsm
  import fxd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [4:0] cg,
  input  logic       bypass,
  input  logic       data_ok,
  input  logic [3:0] nib,
  input  logic       is_i,
  input  logic       is_j,
  input  logic       is_k,
  input  logic       is_t,
  input  logic       is_r,
  output logic       rx_dv,
  output logic       rx_er,
  output logic [3:0] rxd,
  output logic       rxd4,
  output logic       fc_end,
  output logic       ssd_ok,
  output logic       pkt_bad
);
  fr_state_t  st, nst;
  logic       perr, perr_n;
  logic       dv_n, er_n, fc_slot;
  logic [3:0] nib_n;
  logic [4:0] raw_n;

  always_comb begin
    nst = st; perr_n = perr;
    dv_n = 1'b0; er_n = 1'b0; nib_n = '0; raw_n = '0;
    fc_slot = 1'b0; fc_end = 1'b0; ssd_ok = 1'b0; pkt_bad = 1'b0;
    case (st)
      S_IDLE: begin
        if (is_j) nst = S_GOT_J;
        else if (!is_i) begin nst = S_FALSE; fc_slot = 1'b1; end
      end
      S_GOT_J: begin
        if (is_k) begin
          nst = S_DATA; ssd_ok = 1'b1; perr_n = 1'b0;
          dv_n = 1'b1; nib_n = NIB_PRE; raw_n = cg;
        end else if (is_i) begin
          nst = S_IDLE; fc_slot = 1'b1; fc_end = 1'b1;
        end else begin
          nst = S_FALSE; fc_slot = 1'b1;
        end
      end
      S_FALSE: begin
        if (is_i) begin nst = S_IDLE; fc_end = 1'b1; end
        else fc_slot = 1'b1;
      end
      S_DATA: begin
        if (is_t) nst = S_GOT_T;
        else if (is_i) begin
          nst = S_IDLE; dv_n = 1'b1; er_n = 1'b1; raw_n = cg; pkt_bad = 1'b1;
        end else begin
          dv_n = 1'b1; raw_n = cg;
          if (data_ok) nib_n = nib;
          else begin er_n = 1'b1; perr_n = 1'b1; end
        end
      end
      S_GOT_T: begin
        nst = S_IDLE; pkt_bad = perr | ~is_r;
      end
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; perr <= 1'b0;
      rx_dv <= 1'b0; rx_er <= 1'b0; rxd <= '0; rxd4 <= 1'b0;
    end else begin
      st <= nst; perr <= perr_n;
      rx_dv <= dv_n;
      if (bypass) begin
        rx_er <= 1'b0;
        {rxd4, rxd} <= fc_slot ? RAW_FC : (dv_n ? raw_n : 5'b0);
      end else begin
        rx_er <= er_n | fc_slot;
        rxd   <= fc_slot ? NIB_FC : nib_n;
        rxd4  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fxd_stat_cnt.sv
module fxd_stat_cnt
  import fxd_pkg::*;
#(
  parameter int W        = 16,
  parameter bit SATURATE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         msb_warn
);
  localparam logic [31:0] TOP = (32'd1 << W) - 32'd1;
  logic [W-1:0] nxt;
  logic [31:0]  step;

  generate
    if (SATURATE) begin : g_sat
      assign step = cnt_step(32'(cnt), TOP, inc, clr, 1'b1);
    end else begin : g_wrap
      assign step = cnt_step(32'(cnt), TOP, inc, clr, 1'b0);
    end
  endgenerate
  assign nxt = step[W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; msb_warn <= 1'b0;
    end else begin
      cnt      <= nxt;
      msb_warn <= ~cnt[W-1] & nxt[W-1];
    end
  end
endmodule

// File: rtl/fxd_link_mon.sv
module fxd_link_mon (
  input  logic clk,
  input  logic rst_n,
  input  logic fc_end,
  input  logic ssd_ok,
  output logic link_ok,
  output logic link_chg
);
  logic last_fc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_ok <= 1'b1; link_chg <= 1'b0; last_fc <= 1'b0;
    end else begin
      link_chg <= 1'b0;
      if (fc_end) begin
        last_fc <= 1'b1;
        if (last_fc && link_ok) begin link_ok <= 1'b0; link_chg <= 1'b1; end
      end else if (ssd_ok) begin
        last_fc <= 1'b0;
        if (!link_ok) begin link_ok <= 1'b1; link_chg <= 1'b1; end
      end
    end
  end
endmodule

// File: rtl/fx_rx_decoder.sv
module fx_rx_decoder #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       cg,
  input  logic             bypass,
  input  logic             cnt_rd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic [3:0]       rxd,
  output logic             rxd4,
  output logic [CNT_W-1:0] fc_count,
  output logic [CNT_W-1:0] err_count,
  output logic             cnt_warn,
  output logic             link_ok,
  output logic             link_chg
);
  logic       data_ok, is_i, is_j, is_k, is_t, is_r;
  logic [3:0] nib;
  logic       fc_end, ssd_ok, pkt_bad;
  logic       fc_warn, err_warn;

  fxd_sym_map u_map (
    .cg(cg), .data_ok(data_ok), .nib(nib),
    .is_i(is_i), .is_j(is_j), .is_k(is_k), .is_t(is_t), .is_r(is_r)
  );

  fxd_frame_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .cg(cg), .bypass(bypass),
    .data_ok(data_ok), .nib(nib),
    .is_i(is_i), .is_j(is_j), .is_k(is_k), .is_t(is_t), .is_r(is_r),
    .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd), .rxd4(rxd4),
    .fc_end(fc_end), .ssd_ok(ssd_ok), .pkt_bad(pkt_bad)
  );

  fxd_stat_cnt #(.W(CNT_W), .SATURATE(1'b1)) u_fc_cnt (
    .clk(clk), .rst_n(rst_n), .inc(fc_end), .clr(cnt_rd),
    .cnt(fc_count), .msb_warn(fc_warn)
  );

  fxd_stat_cnt #(.W(CNT_W), .SATURATE(1'b0)) u_err_cnt (
    .clk(clk), .rst_n(rst_n), .inc(pkt_bad), .clr(cnt_rd),
    .cnt(err_count), .msb_warn(err_warn)
  );

  fxd_link_mon u_link (
    .clk(clk), .rst_n(rst_n), .fc_end(fc_end), .ssd_ok(ssd_ok),
    .link_ok(link_ok), .link_chg(link_chg)
  );

  assign cnt_warn = fc_warn | err_warn;
endmodule

// File: rtl/fx_rx_decoder_chk.sv
module fx_rx_decoder_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [4:0]       cg,
  input logic             cnt_rd,
  input logic             rx_dv,
  input logic             rx_er,
  input logic [3:0]       rxd,
  input logic [CNT_W-1:0] fc_count,
  input logic [CNT_W-1:0] err_count,
  input logic             link_ok,
  input logic             link_chg
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_dv_after_k_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_dv) |-> ($past(cg) == 5'b10001));

  p_fc_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_er && !rx_dv) |-> (rxd == 4'b1110));

  p_fc_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_rd |=> (fc_count == $past(fc_count) || fc_count == $past(fc_count) + 1'b1));

  p_fc_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_count == CMAX && !cnt_rd) |=> (fc_count == CMAX));

  p_err_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_rd |=> (err_count == $past(err_count) || err_count == $past(err_count) + 1'b1));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_rd |=> (fc_count <= 1 && err_count <= 1));

  p_link_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ok) |-> link_chg);

  p_link_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ok) |-> link_chg);
endmodule

bind fx_rx_decoder fx_rx_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cg(cg), .cnt_rd(cnt_rd),
  .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd),
  .fc_count(fc_count), .err_count(err_count),
  .link_ok(link_ok), .link_chg(link_chg)
);

// File: tb/tb_fx_rx_decoder.sv
`timescale 1ns/1ps
module tb_fx_rx_decoder;
  localparam int W = 4;
  localparam int TOPV = (1 << W) - 1;
  localparam logic [4:0] I_ = 5'b11111, J_ = 5'b11000, K_ = 5'b10001,
                         T_ = 5'b01101, R_ = 5'b00111;

  logic clk = 1'b0, rst_n = 1'b0, bypass = 1'b0, cnt_rd = 1'b0;
  logic [4:0] cg = 5'b11111;
  logic rx_dv, rx_er, rxd4, cnt_warn, link_ok, link_chg;
  logic [3:0] rxd;
  logic [W-1:0] fc_count, err_count;
  int n_chk = 0, n_fail = 0, exp_fc = 0, exp_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fx_rx_decoder #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .cg(cg), .bypass(bypass), .cnt_rd(cnt_rd),
    .rx_dv(rx_dv), .rx_er(rx_er), .rxd(rxd), .rxd4(rxd4),
    .fc_count(fc_count), .err_count(err_count), .cnt_warn(cnt_warn),
    .link_ok(link_ok), .link_chg(link_chg)
  );

  function automatic logic [4:0] enc(input int n);
    case (n)
      0: return 5'b11110;  1: return 5'b01001;  2: return 5'b10100;  3: return 5'b10101;
      4: return 5'b01010;  5: return 5'b01011;  6: return 5'b01110;  7: return 5'b01111;
      8: return 5'b10010;  9: return 5'b10011; 10: return 5'b10110; 11: return 5'b10111;
      12: return 5'b11010; 13: return 5'b11011; 14: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  function automatic bit is_data(input logic [4:0] c);
    for (int n = 0; n < 16; n++) if (enc(n) == c) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step_rd(input logic [4:0] c, input logic rd);
    cg = c; cnt_rd = rd;
    @(posedge clk); @(negedge clk);
    cnt_rd = 1'b0;
  endtask

  task automatic step(input logic [4:0] c);
    step_rd(c, 1'b0);
  endtask

  task automatic fc_done(input logic rd);
    int old;
    old = exp_fc;
    exp_fc = rd ? 1 : ((exp_fc < TOPV) ? exp_fc + 1 : TOPV);
    chk("R6 fc_count", fc_count, exp_fc);
    chk("R10 warn on fc", cnt_warn, (!rd && old < 8 && exp_fc >= 8) ? 1 : 0);
  endtask

  task automatic good_pkt();
    step(J_); step(K_); chk("R2 dv at K", rx_dv, 1);
    step(enc(3)); chk("R1 nibble", rxd, 3);
    step(T_); step(R_); step(I_);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    chk("R3 reset dv", rx_dv, 0); chk("R3 reset er", rx_er, 0);
    chk("R9 reset link", link_ok, 1); chk("R6 reset fc", fc_count, 0);
    chk("R7 reset err", err_count, 0); chk("R10 reset warn", cnt_warn, 0);
    for (int i = 0; i < 3; i++) begin
      step(I_);
      chk("R3 idle dv", rx_dv, 0); chk("R3 idle er", rx_er, 0); chk("R3 idle rxd", rxd, 0);
    end

    // R1/R2/R3: full data sweep in one stream
    step(J_); chk("R2 J slot dv", rx_dv, 0);
    step(K_); chk("R2 K dv", rx_dv, 1); chk("R2 preamble", rxd, 5);
    for (int n = 0; n < 16; n++) begin
      step(enc(n));
      chk("R1 dv", rx_dv, 1); chk("R1 rxd", rxd, n); chk("R1 er", rx_er, 0);
    end
    step(T_); chk("R3 T slot dv", rx_dv, 0);
    step(R_); chk("R3 R slot dv", rx_dv, 0);
    chk("R7 clean packet", err_count, 0);
    step(I_);

    // R4 sweep of every non-data code inside a stream
    for (int c = 0; c < 32; c++) begin
      logic [4:0] cc;
      int old;
      cc = 5'(c);
      if (is_data(cc) || cc == T_ || cc == I_) continue;
      step(J_); step(K_);
      step(cc); chk("R4 viol dv", rx_dv, 1); chk("R4 viol er", rx_er, 1);
      step(T_);
      old = exp_err;
      step(R_);
      exp_err = (exp_err + 1) % (TOPV + 1);
      chk("R7 err per packet", err_count, exp_err);
      chk("R10 warn on err", cnt_warn, (old < 8 && exp_err >= 8) ? 1 : 0);
      step(I_);
    end

    // R7: three errors in one packet count once, then wrap
    step(J_); step(K_); step(5'b00000); step(5'b00001); step(5'b00100); step(T_); step(R_);
    exp_err = (exp_err + 1) % (TOPV + 1);
    chk("R7 once per packet", err_count, exp_err);
    step(I_);
    step(J_); step(K_); step(5'b00010); step(T_); step(R_);
    exp_err = (exp_err + 1) % (TOPV + 1);
    chk("R7 wrap", err_count, exp_err);
    step(I_);

    // R12 early endings
    step(J_); step(K_); step(enc(7));
    step(I_); chk("R12 early idle dv", rx_dv, 1); chk("R12 early idle er", rx_er, 1);
    exp_err++; chk("R12 early idle counted", err_count, exp_err);
    step(J_); step(K_); step(enc(1)); step(T_); step(I_);
    exp_err++; chk("R12 T without R counted", err_count, exp_err);
    step(I_);

    // R8 plain clear
    step_rd(I_, 1'b1); exp_fc = 0; exp_err = 0;
    chk("R8 clear fc", fc_count, 0); chk("R8 clear err", err_count, 0);

    // R5 false carrier from idle
    step(5'b00101); chk("R5 fc dv", rx_dv, 0); chk("R5 fc er", rx_er, 1); chk("R5 fc rxd", rxd, 14);
    step(5'b00110); chk("R5 fc er 2nd slot", rx_er, 1);
    step(I_); chk("R5 end er", rx_er, 0); fc_done(1'b0);
    chk("R9 single fc keeps link", link_ok, 1);
    good_pkt();
    // R5 J then non-K
    step(J_); step(5'b00100); chk("R5 bad ssd er", rx_er, 1); chk("R5 bad ssd rxd", rxd, 14);
    step(I_); fc_done(1'b0); chk("R9 link after separated fc", link_ok, 1);
    // R9 second consecutive: J then idle
    step(J_); step(I_); chk("R5 J-idle er", rx_er, 1); fc_done(1'b0);
    chk("R9 link dropped", link_ok, 0); chk("R9 link_chg drop", link_chg, 1);
    step(I_); chk("R9 link_chg one clock", link_chg, 0);
    step(5'b00101); step(I_); fc_done(1'b0);
    chk("R9 stays down", link_ok, 0); chk("R9 no repeat chg", link_chg, 0);
    step(J_); step(K_); chk("R9 link restored", link_ok, 1); chk("R9 link_chg restore", link_chg, 1);
    step(T_); step(R_); step(I_);

    // R6 saturation sweep
    for (int i = 0; i < 14; i++) begin
      step(5'b00101); step(I_); fc_done(1'b0);
    end
    chk("R6 saturated", fc_count, TOPV);
    // R8 clear meets increment
    step(5'b00101); step_rd(I_, 1'b1); fc_done(1'b1);
    chk("R8 err cleared alongside", err_count, 0);
    step(J_); step(K_); step(5'b00000); step(T_); step_rd(R_, 1'b1);
    chk("R8 err clear+inc", err_count, 1); chk("R8 fc cleared", fc_count, 0);
    exp_fc = 0;
    step(I_);

    // R11 raw mode
    bypass = 1'b1;
    step(I_);
    step(J_); step(K_); chk("R11 raw K", {rxd4, rxd}, 5'b10001);
    step(enc(9)); chk("R11 raw data", {rxd4, rxd}, enc(9)); chk("R11 er low", rx_er, 0);
    step(T_); step(R_); step(I_);
    step(5'b00101); chk("R11 raw fc", {rxd4, rxd}, 5'b11110);
    chk("R11 raw fc dv", rx_dv, 0); chk("R11 raw fc er", rx_er, 0);
    step(I_);
    bypass = 1'b0;
    step(I_);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end
endmodule